// File: doc/BRIEF.md
# Interrupt Context Save/Restore Sequencer

This block performs the register-frame traffic for interrupt entry and interrupt return in a small processor. When the interrupt logic presents an accepted request and the core signals that the current instruction has retired, the sequencer takes a snapshot of the core's dedicated registers. It then writes those 12 bytes, one per cycle, onto the system stack through a byte-wide synchronous memory port. After the last byte is written, it issues a single update strobe. That strobe carries the new program bank and program counter from the vector inputs, a status word whose level mask field now holds the accepted level and whose stack-select flag is set, and the lowered stack pointer.

On a return command the sequencer reads the same 12 bytes back in the opposite order, starting at the current stack pointer and moving upward. It then issues an update strobe that carries every restored register and the raised stack pointer. The core holds the live registers and applies the values on the update strobe. `busy` tells the core that a sequence is under way. While `busy` is high, new accept and return commands have no effect.

Top module: `irq_ctx_seq`

## Requirements
- R1: An entry starts only in a cycle where `accept` and `insn_done` are both high and `busy` is low. `accept` without `insn_done` leaves `busy` low and causes no memory access.
- R2: `busy` rises in the cycle after a start. It stays high for 13 cycles on entry (12 writes and 1 update cycle) and for 14 cycles on return (12 reads, 1 drain cycle and 1 update cycle). It falls right after the `upd_valid` cycle.
- R3: Entry makes exactly 12 byte writes on 12 consecutive cycles, with `mem_re` low. The write of index k (k = 0..11) goes to stack pointer `cur_ssp`-1-k, so the pointer is decremented before each push. The data order by k is: status[15:8], status[7:0], PC[15:8], PC[7:0], program bank, data bank, additional data bank, direct page, then accumulator bytes [31:24], [23:16], [15:8], [7:0].
- R4: The entry update strobe gives `upd_pcb` = `vec_bank`, `upd_pc` = `vec_pc` and `upd_ssp` = `cur_ssp`-12. The accumulator, direct page, data bank and additional data bank outputs equal the values captured at the start.
- R5: On the entry update, `upd_ps` equals the captured status word with bits [15:13] (level mask) replaced by `accept_level` and bit 5 (stack select) set to 1. All other bits are kept.
- R6: Return makes exactly 12 byte reads on 12 consecutive cycles, with `mem_we` low. The read of index j goes to `cur_ssp`+j, so the pointer is incremented after each pop, and read data is expected one cycle after `mem_re`.
- R7: The return update strobe restores all registers from the popped bytes. The push order is reversed, so a return that follows an entry gives back the original register values, including the pre-entry status word. `upd_ssp` = `cur_ssp`+12.
- R8: While `busy` is high, `accept` and `ret_cmd` are ignored. The bytes written still come from the snapshot taken at the start, and no new sequence follows the current one.
- R9: After reset, `busy`, `mem_we`, `mem_re` and `upd_valid` are low. Whenever `busy` is low, no memory access or update strobe occurs.
- R10: If an entry start and `ret_cmd` occur in the same cycle, the entry wins and the return command is dropped.
- R11: The bank half of `mem_addr` is `cur_ssb`, captured at the start, for the whole sequence. The pointer half wraps modulo 2^16 without changing the bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| accept | input | 1 | Accepted interrupt request |
| insn_done | input | 1 | Current instruction has retired |
| accept_level | input | 3 | Level of the accepted request |
| vec_pc | input | 16 | Vector program counter |
| vec_bank | input | 8 | Vector program bank |
| ret_cmd | input | 1 | Return-from-interrupt command |
| cur_acc | input | 32 | Live accumulator |
| cur_dpr | input | 8 | Live direct page register |
| cur_adb | input | 8 | Live additional data bank |
| cur_dtb | input | 8 | Live data bank |
| cur_pcb | input | 8 | Live program bank |
| cur_pc | input | 16 | Live program counter |
| cur_ps | input | 16 | Live status word |
| cur_ssb | input | 8 | System stack bank |
| cur_ssp | input | 16 | System stack pointer |
| busy | output | 1 | Sequence in progress |
| mem_addr | output | 24 | Byte address {bank, pointer} |
| mem_we | output | 1 | Byte write strobe |
| mem_wdata | output | 8 | Byte write data |
| mem_re | output | 1 | Byte read strobe |
| mem_rdata | input | 8 | Read data, valid one cycle after `mem_re` |
| upd_valid | output | 1 | One-cycle register update strobe |
| upd_acc | output | 32 | Accumulator to load |
| upd_dpr | output | 8 | Direct page to load |
| upd_adb | output | 8 | Additional data bank to load |
| upd_dtb | output | 8 | Data bank to load |
| upd_pcb | output | 8 | Program bank to load |
| upd_pc | output | 16 | Program counter to load |
| upd_ps | output | 16 | Status word to load |
| upd_ssp | output | 16 | Stack pointer to load |

## Verification
The assertions check these properties on every cycle:
- the start condition and quiet idle;
- `busy` holding until the update strobe and dropping right after it;
- writes and reads never overlapping;
- the pointer stepping down by one per push and up by one per pop with the bank held;
- the stack-select bit being set on each entry update.

Only the bench scenarios can show the following:
- the byte order of the frame against the register values;
- the vector and level substitution;
- the full round trip back to the original registers;
- pointer wrap at zero;
- the snapshot staying unchanged when inputs are poked mid-sequence;
- the entry-over-return tie.

// File: rtl/ctx_seq_pkg.sv
package ctx_seq_pkg;
  localparam int FRAME_BYTES = 12;
  localparam int FRAME_W     = 8 * FRAME_BYTES;
  localparam int CNT_W       = $clog2(FRAME_BYTES);
  localparam int LVL_W       = 3;
  localparam int ILM_LSB     = 13;
  localparam int ILM_MSB     = ILM_LSB + LVL_W - 1;
  localparam int S_BIT       = 5;

  // Field order is the push order: most significant field leaves first.
  typedef struct packed {
    logic [15:0] ps;
    logic [15:0] pc;
    logic [7:0]  pcb;
    logic [7:0]  dtb;
    logic [7:0]  adb;
    logic [7:0]  dpr;
    logic [31:0] acc;
  } ctx_frame_t;

  typedef enum logic [2:0] {
    S_IDLE, S_PUSH, S_LOAD, S_POP, S_DRAIN, S_RESTORE
  } seq_state_t;

  // Byte k of the push sequence (k = 0 is the top byte of the frame).
  function automatic logic [7:0] frame_byte(ctx_frame_t f, logic [CNT_W-1:0] k);
    logic [FRAME_W-1:0] s;
    s = FRAME_W'(f) >> (8 * (FRAME_BYTES - 1 - int'(k)));
    return s[7:0];
  endfunction

  // Status word after entry: level mask replaced, stack select set.
  function automatic logic [15:0] enter_ps(logic [15:0] ps, logic [LVL_W-1:0] lvl);
    logic [15:0] r;
    r = ps;
    r[ILM_MSB:ILM_LSB] = lvl;
    r[S_BIT] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/ctx_seq_ctrl.sv
module ctx_seq_ctrl
  import ctx_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_entry,
  input  logic             start_ret,
  output seq_state_t       state,
  output logic [CNT_W-1:0] cnt,
  output logic             rd_pend
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BYTES - 1);

  logic last_byte;
  assign last_byte = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      rd_pend <= 1'b0;
    end else begin
      rd_pend <= (state == S_POP);
      unique case (state)
        S_IDLE: begin
          cnt <= '0;
          if (start_entry)    state <= S_PUSH;
          else if (start_ret) state <= S_POP;
        end
        S_PUSH: begin
          if (last_byte) begin
            state <= S_LOAD;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_LOAD:  state <= S_IDLE;
        S_POP: begin
          if (last_byte) begin
            state <= S_DRAIN;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_DRAIN:   state <= S_RESTORE;
        S_RESTORE: state <= S_IDLE;
        default:   state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ctx_seq_addr.sv
module ctx_seq_addr
  import ctx_seq_pkg::*;
#(
  parameter int SP_W   = 16,
  parameter int BANK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [BANK_W-1:0] cur_ssb,
  input  logic [SP_W-1:0]   cur_ssp,
  input  logic              is_push,
  input  logic [CNT_W-1:0]  cnt,
  output logic [BANK_W-1:0] bank_q,
  output logic [SP_W-1:0]   ptr,
  output logic [SP_W-1:0]   ssp_after_push,
  output logic [SP_W-1:0]   ssp_after_pop
);
  localparam logic [SP_W-1:0] SPAN = SP_W'(FRAME_BYTES);

  logic [SP_W-1:0] base_q;

  function automatic logic [SP_W-1:0] push_ptr(logic [SP_W-1:0] b, logic [CNT_W-1:0] k);
    return b - SP_W'(1) - SP_W'(k);
  endfunction

  function automatic logic [SP_W-1:0] pop_ptr(logic [SP_W-1:0] b, logic [CNT_W-1:0] k);
    return b + SP_W'(k);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      bank_q <= '0;
    end else if (capture) begin
      base_q <= cur_ssp;
      bank_q <= cur_ssb;
    end
  end

  assign ptr            = is_push ? push_ptr(base_q, cnt) : pop_ptr(base_q, cnt);
  assign ssp_after_push = base_q - SPAN;
  assign ssp_after_pop  = base_q + SPAN;
endmodule

// File: rtl/ctx_seq_frame.sv
module ctx_seq_frame
  import ctx_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  ctx_frame_t       cur_frame,
  input  logic [LVL_W-1:0] lvl_in,
  input  logic [15:0]      vpc_in,
  input  logic [7:0]       vbank_in,
  input  logic             shift_en,
  input  logic [7:0]       shift_byte,
  output ctx_frame_t       frame_q,
  output logic [LVL_W-1:0] lvl_q,
  output logic [15:0]      vpc_q,
  output logic [7:0]       vbank_q
);
  logic [FRAME_W-1:0] bits_q;
  assign frame_q = ctx_frame_t'(bits_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q  <= '0;
      lvl_q   <= '0;
      vpc_q   <= '0;
      vbank_q <= '0;
    end else if (capture) begin
      bits_q  <= FRAME_W'(cur_frame);
      lvl_q   <= lvl_in;
      vpc_q   <= vpc_in;
      vbank_q <= vbank_in;
    end else if (shift_en) begin
      // First popped byte is the last pushed one; it lands at the bottom.
      bits_q <= {shift_byte, bits_q[FRAME_W-1:8]};
    end
  end
endmodule

// File: rtl/irq_ctx_seq.sv
module irq_ctx_seq
  import ctx_seq_pkg::*;
#(
  parameter int SP_W   = 16,
  parameter int BANK_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     accept,
  input  logic                     insn_done,
  input  logic [2:0]               accept_level,
  input  logic [15:0]              vec_pc,
  input  logic [7:0]               vec_bank,
  input  logic                     ret_cmd,
  input  logic [31:0]              cur_acc,
  input  logic [7:0]               cur_dpr,
  input  logic [7:0]               cur_adb,
  input  logic [7:0]               cur_dtb,
  input  logic [7:0]               cur_pcb,
  input  logic [15:0]              cur_pc,
  input  logic [15:0]              cur_ps,
  input  logic [BANK_W-1:0]        cur_ssb,
  input  logic [SP_W-1:0]          cur_ssp,
  output logic                     busy,
  output logic [BANK_W+SP_W-1:0]   mem_addr,
  output logic                     mem_we,
  output logic [7:0]               mem_wdata,
  output logic                     mem_re,
  input  logic [7:0]               mem_rdata,
  output logic                     upd_valid,
  output logic [31:0]              upd_acc,
  output logic [7:0]               upd_dpr,
  output logic [7:0]               upd_adb,
  output logic [7:0]               upd_dtb,
  output logic [7:0]               upd_pcb,
  output logic [15:0]              upd_pc,
  output logic [15:0]              upd_ps,
  output logic [SP_W-1:0]          upd_ssp
);
  seq_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic             rd_pend;
  logic             idle;
  logic             start_entry, start_ret;
  logic             ev_entry_done, ev_ret_done;
  ctx_frame_t       live, frame_q, upd;
  logic [LVL_W-1:0] lvl_q;
  logic [15:0]      vpc_q;
  logic [7:0]       vbank_q;
  logic [BANK_W-1:0] bank_q;
  logic [SP_W-1:0]  ptr, ssp_after_push, ssp_after_pop;

  assign idle        = (state == S_IDLE);
  assign start_entry = idle & accept & insn_done;
  assign start_ret   = idle & ret_cmd & ~start_entry;

  assign live = '{ps: cur_ps, pc: cur_pc, pcb: cur_pcb, dtb: cur_dtb,
                  adb: cur_adb, dpr: cur_dpr, acc: cur_acc};

  ctx_seq_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_entry (start_entry),
    .start_ret   (start_ret),
    .state       (state),
    .cnt         (cnt),
    .rd_pend     (rd_pend)
  );

  ctx_seq_addr #(.SP_W(SP_W), .BANK_W(BANK_W)) u_addr (
    .clk            (clk),
    .rst_n          (rst_n),
    .capture        (start_entry | start_ret),
    .cur_ssb        (cur_ssb),
    .cur_ssp        (cur_ssp),
    .is_push        (state == S_PUSH),
    .cnt            (cnt),
    .bank_q         (bank_q),
    .ptr            (ptr),
    .ssp_after_push (ssp_after_push),
    .ssp_after_pop  (ssp_after_pop)
  );

  ctx_seq_frame u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture    (start_entry),
    .cur_frame  (live),
    .lvl_in     (accept_level),
    .vpc_in     (vec_pc),
    .vbank_in   (vec_bank),
    .shift_en   (rd_pend),
    .shift_byte (mem_rdata),
    .frame_q    (frame_q),
    .lvl_q      (lvl_q),
    .vpc_q      (vpc_q),
    .vbank_q    (vbank_q)
  );

  assign ev_entry_done = (state == S_LOAD);
  assign ev_ret_done   = (state == S_RESTORE);

  assign busy      = ~idle;
  assign mem_we    = (state == S_PUSH);
  assign mem_re    = (state == S_POP);
  assign mem_addr  = {bank_q, ptr};
  assign mem_wdata = frame_byte(frame_q, cnt);
  assign upd_valid = ev_entry_done | ev_ret_done;

  always_comb begin
    upd = frame_q;
    if (ev_entry_done) begin
      upd.pcb = vbank_q;
      upd.pc  = vpc_q;
      upd.ps  = enter_ps(frame_q.ps, lvl_q);
    end
  end

  assign upd_acc = upd.acc;
  assign upd_dpr = upd.dpr;
  assign upd_adb = upd.adb;
  assign upd_dtb = upd.dtb;
  assign upd_pcb = upd.pcb;
  assign upd_pc  = upd.pc;
  assign upd_ps  = upd.ps;
  assign upd_ssp = ev_entry_done ? ssp_after_push : ssp_after_pop;
endmodule

// File: rtl/irq_ctx_seq_chk.sv
module irq_ctx_seq_chk
  import ctx_seq_pkg::*;
#(
  parameter int AW = 24,
  parameter int SP_W = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          accept,
  input logic          insn_done,
  input logic          busy,
  input logic          mem_we,
  input logic          mem_re,
  input logic [AW-1:0] mem_addr,
  input logic          upd_valid,
  input logic [15:0]   upd_ps,
  input logic          ev_entry_done
);
  AST_START_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && insn_done && !busy) |=> busy); // R1
  AST_NO_START_MIDINSN: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !insn_done && !mem_re && !$past(busy) && !accept && !insn_done) |-> !mem_we); // R1
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !upd_valid) |=> busy); // R2
  AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> !busy); // R2
  AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re)); // R3
  AST_PUSH_PREDEC: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr[SP_W-1:0] == $past(mem_addr[SP_W-1:0]) - SP_W'(1))); // R3
  AST_POP_POSTINC: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re && $past(mem_re)) |-> (mem_addr[SP_W-1:0] == $past(mem_addr[SP_W-1:0]) + SP_W'(1))); // R6
  AST_ENTRY_SETS_S: assert property (@(posedge clk) disable iff (!rst_n)
    ev_entry_done |-> (upd_valid && upd_ps[S_BIT])); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_we && !mem_re && !upd_valid)); // R9
  AST_BANK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_we && $past(mem_we)) || (mem_re && $past(mem_re))) |-> $stable(mem_addr[AW-1:SP_W])); // R11
endmodule

bind irq_ctx_seq irq_ctx_seq_chk #(.AW(BANK_W+SP_W), .SP_W(SP_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .accept        (accept),
  .insn_done     (insn_done),
  .busy          (busy),
  .mem_we        (mem_we),
  .mem_re        (mem_re),
  .mem_addr      (mem_addr),
  .upd_valid     (upd_valid),
  .upd_ps        (upd_ps),
  .ev_entry_done (ev_entry_done)
);

// File: tb/irq_ctx_seq_test.sv
module irq_ctx_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 4;

  typedef struct packed {
    logic [31:0] acc;
    logic [7:0]  dpr, adb, dtb, pcb;
    logic [15:0] pc, ps;
    logic [7:0]  ssb;
    logic [15:0] ssp;
    logic [2:0]  lvl;
    logic [7:0]  vbank;
    logic [15:0] vpc;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{32'h1122_3344, 8'h55, 8'h66, 8'h77, 8'h88, 16'h99AA, 16'h0000, 8'h01, 16'h0100, 3'd3, 8'hFF, 16'h8000},
    '{32'hDEAD_BEEF, 8'h01, 8'h02, 8'h03, 8'h04, 16'h1234, 16'hFFFF, 8'h7E, 16'h0005, 3'd0, 8'h10, 16'h4242},
    '{32'h0000_0001, 8'hA5, 8'h5A, 8'hC3, 8'h3C, 16'hFFFE, 16'h4C10, 8'hC0, 16'hFFF0, 3'd7, 8'h00, 16'h0001},
    '{32'h8070_6050, 8'h00, 8'hFF, 8'h00, 8'hFF, 16'h0000, 16'hA05F, 8'h20, 16'h0080, 3'd5, 8'hAB, 16'hCDEF}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic accept = 0, insn_done = 0, ret_cmd = 0;
  logic [2:0] accept_level = '0;
  logic [15:0] vec_pc = '0, cur_pc = '0, cur_ps = '0, cur_ssp = '0;
  logic [7:0] vec_bank = '0, cur_dpr = '0, cur_adb = '0, cur_dtb = '0, cur_pcb = '0, cur_ssb = '0;
  logic [31:0] cur_acc = '0;
  logic busy, mem_we, mem_re, upd_valid;
  logic [23:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata, upd_dpr, upd_adb, upd_dtb, upd_pcb;
  logic [31:0] upd_acc;
  logic [15:0] upd_pc, upd_ps, upd_ssp;
  logic [7:0] mem [256];
  int tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_ctx_seq uut (
    .clk(clk), .rst_n(rst_n), .accept(accept), .insn_done(insn_done),
    .accept_level(accept_level), .vec_pc(vec_pc), .vec_bank(vec_bank), .ret_cmd(ret_cmd),
    .cur_acc(cur_acc), .cur_dpr(cur_dpr), .cur_adb(cur_adb), .cur_dtb(cur_dtb),
    .cur_pcb(cur_pcb), .cur_pc(cur_pc), .cur_ps(cur_ps), .cur_ssb(cur_ssb), .cur_ssp(cur_ssp),
    .busy(busy), .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_re(mem_re), .mem_rdata(mem_rdata), .upd_valid(upd_valid),
    .upd_acc(upd_acc), .upd_dpr(upd_dpr), .upd_adb(upd_adb), .upd_dtb(upd_dtb),
    .upd_pcb(upd_pcb), .upd_pc(upd_pc), .upd_ps(upd_ps), .upd_ssp(upd_ssp)
  );

  // Synchronous byte memory, low 8 address bits only.
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] push_byte(vec_t v, int k);
    case (k)
      0: return v.ps[15:8];   1: return v.ps[7:0];
      2: return v.pc[15:8];   3: return v.pc[7:0];
      4: return v.pcb;        5: return v.dtb;
      6: return v.adb;        7: return v.dpr;
      8: return v.acc[31:24]; 9: return v.acc[23:16];
      10: return v.acc[15:8]; default: return v.acc[7:0];
    endcase
  endfunction

  task automatic drive_regs(vec_t v);
    cur_acc = v.acc; cur_dpr = v.dpr; cur_adb = v.adb; cur_dtb = v.dtb;
    cur_pcb = v.pcb; cur_pc = v.pc; cur_ps = v.ps; cur_ssb = v.ssb; cur_ssp = v.ssp;
    accept_level = v.lvl; vec_pc = v.vpc; vec_bank = v.vbank;
  endtask

  // Entry; poke = disturb inputs mid-push, with_ret = raise ret_cmd at start.
  task automatic do_entry(vec_t v, bit poke, bit with_ret);
    logic [15:0] exp_ps;
    @(negedge clk);
    drive_regs(v);
    accept = 1; insn_done = 1; ret_cmd = with_ret;
    @(negedge clk);
    accept = 0; insn_done = 0; ret_cmd = 0;
    for (int k = 0; k < 12; k++) begin
      if (poke && k == 4) begin
        accept = 1; insn_done = 1; ret_cmd = 1;
        cur_acc = ~v.acc; cur_ps = ~v.ps; cur_ssp = v.ssp + 16'h0040; cur_ssb = ~v.ssb;
      end
      if (poke && k == 5) begin accept = 0; insn_done = 0; ret_cmd = 0; end
      check(mem_we && !mem_re && busy, with_ret ? "R10" : "R3", "write strobe", {mem_we, mem_re, busy}, 3'b101);
      check(mem_addr == {v.ssb, v.ssp - 16'(k + 1)}, poke ? "R8" : "R11", "push address",
            mem_addr, {v.ssb, v.ssp - 16'(k + 1)});
      check(mem_wdata == push_byte(v, k), poke ? "R8" : "R3", "push data", mem_wdata, push_byte(v, k));
      @(negedge clk);
    end
    exp_ps = (v.ps & 16'h1FDF) | (16'(v.lvl) << 13) | 16'h0020;
    check(upd_valid && busy, "R2", "entry update strobe", {upd_valid, busy}, 2'b11);
    check(upd_pcb == v.vbank && upd_pc == v.vpc, "R4", "vector load", {upd_pcb, upd_pc}, {v.vbank, v.vpc});
    check(upd_ssp == v.ssp - 16'd12, "R4", "entry stack pointer", upd_ssp, v.ssp - 16'd12);
    check(upd_acc == v.acc && {upd_dpr, upd_adb, upd_dtb} == {v.dpr, v.adb, v.dtb},
          "R4", "unchanged registers", upd_acc, v.acc);
    check(upd_ps == exp_ps, "R5", "entry status word", upd_ps, exp_ps);
    @(negedge clk);
    check(!busy && !mem_we && !upd_valid, poke ? "R8" : "R2", "idle after entry", busy, 0);
  endtask

  task automatic do_return(vec_t v);
    logic [15:0] sp;
    sp = v.ssp - 16'd12;
    @(negedge clk);
    cur_ssb = v.ssb; cur_ssp = sp; ret_cmd = 1;
    @(negedge clk);
    ret_cmd = 0;
    for (int j = 0; j < 12; j++) begin
      check(mem_re && !mem_we, "R6", "read strobe", {mem_re, mem_we}, 2'b10);
      check(mem_addr == {v.ssb, sp + 16'(j)}, "R6", "pop address", mem_addr, {v.ssb, sp + 16'(j)});
      @(negedge clk);
    end
    check(busy && !mem_re && !upd_valid, "R2", "drain cycle", {busy, mem_re, upd_valid}, 3'b100);
    @(negedge clk);
    check(upd_valid, "R7", "return update strobe", upd_valid, 1);
    check(upd_acc == v.acc, "R7", "restored accumulator", upd_acc, v.acc);
    check({upd_dpr, upd_adb, upd_dtb, upd_pcb} == {v.dpr, v.adb, v.dtb, v.pcb},
          "R7", "restored banks", {upd_dpr, upd_adb, upd_dtb, upd_pcb}, {v.dpr, v.adb, v.dtb, v.pcb});
    check(upd_pc == v.pc && upd_ps == v.ps, "R7", "restored pc/status", {upd_pc, upd_ps}, {v.pc, v.ps});
    check(upd_ssp == v.ssp, "R7", "return stack pointer", upd_ssp, v.ssp);
    @(negedge clk);
    check(!busy, "R2", "idle after return", busy, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !mem_we && !mem_re && !upd_valid, "R9", "reset state",
          {busy, mem_we, mem_re, upd_valid}, 0);
    rst_n = 1;

    // Table walk: entry then return for each vector.
    for (int i = 0; i < NVEC; i++) begin
      do_entry(VECS[i], 1'b0, 1'b0);
      do_return(VECS[i]);
    end

    // R1: accept outside an instruction boundary is ignored.
    @(negedge clk);
    drive_regs(VECS[0]);
    accept = 1; insn_done = 0;
    @(negedge clk);
    accept = 0;
    check(!busy && !mem_we && !mem_re, "R1", "accept without boundary", {busy, mem_we, mem_re}, 0);
    @(negedge clk);
    check(!busy, "R1", "still idle", busy, 0);

    // R8: commands while busy are ignored; snapshot kept.
    do_entry(VECS[3], 1'b1, 1'b0);
    do_return(VECS[3]);

    // R10: entry and return together -> entry.
    do_entry(VECS[2], 1'b0, 1'b1);
    do_return(VECS[2]);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule